// File: doc/BRIEF.md
# Host Parameter Register Interface

This block is the parameter and status register file that a host controller reaches through a simple memory-mapped read/write port. Each access presents a 16-bit address, a size code, write data and a read or write strobe. One clock later the block returns an acknowledge, read data and an error flag. An external serial engine translates host frames into these strobes. The block owns the drive-control settings: rotation direction, switching frequency, output polarity, dead time, base frequency, ramp rate, speed, voltage boost, fault timeout and bus-voltage thresholds. It also exposes live status inputs and a capture-once reset-cause byte.

A single command address at 0x1000 carries many small functions. The byte written there is decoded into a direction change, a reset request, a frequency choice, a polarity choice or a base-frequency choice. Polarity and dead time may each be set once per reset. The power-stage outputs stay in high impedance until both have been set, and frequency changes are refused until then. A setup byte reports which mandatory parameters have been written. Multi-byte values are big-endian, so the byte at the lower address is the most significant. The live measured frequency can be read one byte at a time without tearing.

Top module: `host_param_regs`

## Requirements
- R1: Every cycle with host_rd or host_wr high is followed, one cycle later, by host_ack high with host_rdata and host_err; cycles without a strobe give host_ack low. Both strobes together, or size code 3, give host_err. Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. host_rdata is zero on errors and on writes.
- R2: A read at an address below 0x0060 or above 0xEE03 gives host_err, except at 0x0001, 0x0036 and 0xFE01. A read of an unmapped or write-only address inside that window returns zero without error.
- R3: A 1-byte write to 0x1000 is decoded as follows. 0x10 drives dir_cmd to 1 (forward), 0x11 to 2 (reverse) and 0x20 to 0 (stop). 0x60 clears base_50hz and 0x61 sets it. 0x30 raises reset_req for exactly one cycle. Any other byte gives host_err and changes nothing. After reset dir_cmd is 0.
- R4: Polarity and dead time are write-once. The command bytes 0x50, 0x54, 0x58 and 0x5C set pwm_pol to 0, 1, 2 and 3. Dead time is written as one byte at 0x0036. A second write to either gives host_err and keeps the first value.
- R5: pwm_hiz stays high from reset until both polarity and dead time are set, and then stays low. The command bytes 0x41, 0x42, 0x44 and 0x48 set pwm_freq to 0, 1, 2 and 3. Such a byte gives host_err while pwm_hiz is high. pwm_freq resets to 2.
- R6: The setup byte at 0x00AE reads as {3'b111, base set, speed set, acceleration set, polarity set, dead time set}, which is 0xE0 after reset.
- R7: A cause_load pulse stores cause_in with bits 2 and 0 cleared into the cause byte at 0xFE01. The first read returns that byte and clears it; further reads return 0x00.
- R8: A write whose size differs from the register's size, or whose data exceeds the register's limit, gives host_err and leaves state unchanged. The limits are: 0x7FFF for acceleration (0x0060) and speed (0x0062); 0x3FF for the brake, brownout and overvoltage thresholds (0x0064, 0x0066, 0x0068); 0xFF for boost (0x006C); 0xFFFF for fault timeout (0x006A). A valid acceleration write sets setup bit 2 and a valid speed write sets bit 3.
- R9: Writes to read-only addresses (0x00C8, 0x0001, 0x00AE, 0xFE01, 0x0085, 0x0086, 0xEE00) or to unmapped addresses give host_err. A 1-byte read of 0x00C8 returns status_in and one of 0x0001 returns switch_in.
- R10: A 4-byte read at 0xEE00 returns the VERSION parameter. A 2-byte read at 0x0085 returns meas_freq. A 1-byte read there returns meas_freq[15:8] and captures meas_freq[7:0]. A following 1-byte read of 0x0086 returns the captured byte even if meas_freq has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Access address |
| host_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data, right-justified |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_rdata | output | 32 | Read data, right-justified |
| host_ack | output | 1 | Response valid |
| host_err | output | 1 | Access rejected |
| status_in | input | 8 | Live status byte |
| switch_in | input | 8 | Live switch byte |
| meas_freq | input | 16 | Live measured frequency |
| cause_load | input | 1 | Capture strobe for reset cause |
| cause_in | input | 8 | Reset-cause bits to capture |
| pwm_hiz | output | 1 | Power outputs held in high impedance |
| pwm_freq | output | 2 | Switching frequency choice |
| pwm_pol | output | 2 | Output polarity choice |
| dead_time | output | 8 | Dead time in 125 ns steps |
| base_50hz | output | 1 | Base frequency is 50 Hz |
| dir_cmd | output | 2 | 0 stop, 1 forward, 2 reverse |
| reset_req | output | 1 | One-cycle reset request |
| accel_rate | output | 16 | Ramp rate |
| speed_cmd | output | 16 | Commanded speed |
| boost_lvl | output | 8 | Zero-speed voltage boost |
| fault_tmo | output | 16 | Fault retry delay |
| vbus_brake | output | 10 | Brake threshold |
| vbus_brownout | output | 10 | Undervoltage threshold |
| vbus_over | output | 10 | Overvoltage threshold |

## Verification
A wrong write-once flag shows at the very next access. A repeated polarity or dead-time write comes back with host_err low, or a first one comes back with host_err high. The setup byte and pwm_hiz disagree with the history of writes one cycle after the write that caused the fault. A broken command decode moves dir_cmd, pwm_freq or base_50hz in the cycle after the write, or fails to move them. A stuck cause or snapshot register shows on the second read of the pair, which returns a non-zero or changed byte.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_SWIN  = 16'h0001;
  localparam logic [ADDR_W-1:0] A_DEAD  = 16'h0036;
  localparam logic [ADDR_W-1:0] A_ACCEL = 16'h0060;
  localparam logic [ADDR_W-1:0] A_SPEED = 16'h0062;
  localparam logic [ADDR_W-1:0] A_VBRK  = 16'h0064;
  localparam logic [ADDR_W-1:0] A_VBRN  = 16'h0066;
  localparam logic [ADDR_W-1:0] A_VOVR  = 16'h0068;
  localparam logic [ADDR_W-1:0] A_FTMO  = 16'h006A;
  localparam logic [ADDR_W-1:0] A_BOOST = 16'h006C;
  localparam logic [ADDR_W-1:0] A_FRQH  = 16'h0085;
  localparam logic [ADDR_W-1:0] A_FRQL  = 16'h0086;
  localparam logic [ADDR_W-1:0] A_SETUP = 16'h00AE;
  localparam logic [ADDR_W-1:0] A_STAT  = 16'h00C8;
  localparam logic [ADDR_W-1:0] A_CMD   = 16'h1000;
  localparam logic [ADDR_W-1:0] A_VER   = 16'hEE00;
  localparam logic [ADDR_W-1:0] A_CAUSE = 16'hFE01;

  typedef enum logic [4:0] {
    RG_NONE, RG_DEAD, RG_ACCEL, RG_SPEED, RG_VBRK, RG_VBRN, RG_VOVR,
    RG_FTMO, RG_BOOST, RG_FRQH, RG_FRQL, RG_SETUP, RG_STAT, RG_SWIN,
    RG_CMD, RG_VER, RG_CAUSE
  } reg_id_e;

  typedef struct packed {
    reg_id_e     id;
    logic [2:0]  nbytes;
    logic        rd_ok;
    logic        wr_ok;
    logic [15:0] vmax;
  } reg_desc_t;

  typedef enum logic [2:0] {
    CK_BAD, CK_DIR, CK_RST, CK_FREQ, CK_POL, CK_BASE
  } cmd_kind_e;

  typedef enum logic [1:0] {
    DIR_STOP = 2'd0, DIR_FWD = 2'd1, DIR_REV = 2'd2
  } dir_e;
endpackage

// File: rtl/hpr_addr_dec.sv
module hpr_addr_dec
  import hpr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_LO = 16'h0060,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'hEE03,
  parameter int                THR_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_desc_t         desc,
  output logic              rd_window
);
  localparam logic [15:0] THR_MAX = 16'((1 << THR_W) - 1);

  function automatic reg_desc_t mk(reg_id_e id, int nb, logic r, logic w,
                                   logic [15:0] m);
    reg_desc_t d;
    d.id     = id;
    d.nbytes = 3'(nb);
    d.rd_ok  = r;
    d.wr_ok  = w;
    d.vmax   = m;
    return d;
  endfunction

  always_comb begin
    case (addr)
      A_DEAD:  desc = mk(RG_DEAD,  1, 1'b1, 1'b1, 16'h00FF);
      A_ACCEL: desc = mk(RG_ACCEL, 2, 1'b1, 1'b1, 16'h7FFF);
      A_SPEED: desc = mk(RG_SPEED, 2, 1'b1, 1'b1, 16'h7FFF);
      A_VBRK:  desc = mk(RG_VBRK,  2, 1'b1, 1'b1, THR_MAX);
      A_VBRN:  desc = mk(RG_VBRN,  2, 1'b1, 1'b1, THR_MAX);
      A_VOVR:  desc = mk(RG_VOVR,  2, 1'b1, 1'b1, THR_MAX);
      A_FTMO:  desc = mk(RG_FTMO,  2, 1'b1, 1'b1, 16'hFFFF);
      A_BOOST: desc = mk(RG_BOOST, 1, 1'b1, 1'b1, 16'h00FF);
      A_FRQH:  desc = mk(RG_FRQH,  2, 1'b1, 1'b0, 16'h0000);
      A_FRQL:  desc = mk(RG_FRQL,  1, 1'b1, 1'b0, 16'h0000);
      A_SETUP: desc = mk(RG_SETUP, 1, 1'b1, 1'b0, 16'h0000);
      A_STAT:  desc = mk(RG_STAT,  1, 1'b1, 1'b0, 16'h0000);
      A_SWIN:  desc = mk(RG_SWIN,  1, 1'b1, 1'b0, 16'h0000);
      A_CMD:   desc = mk(RG_CMD,   1, 1'b0, 1'b1, 16'h00FF);
      A_VER:   desc = mk(RG_VER,   4, 1'b1, 1'b0, 16'h0000);
      A_CAUSE: desc = mk(RG_CAUSE, 1, 1'b1, 1'b0, 16'h0000);
      default: desc = mk(RG_NONE,  0, 1'b0, 1'b0, 16'h0000);
    endcase
  end

  // Readable window plus the always-readable exception addresses
  assign rd_window = ((addr >= WIN_LO) && (addr <= WIN_HI)) ||
                     (addr == A_SWIN) || (addr == A_DEAD) || (addr == A_CAUSE);
endmodule

// File: rtl/hpr_cmd_dec.sv
module hpr_cmd_dec
  import hpr_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_e  kind,
  output logic [1:0] arg
);
  always_comb begin
    kind = CK_BAD;
    arg  = 2'd0;
    case (code)
      8'h10: begin kind = CK_DIR;  arg = DIR_FWD;  end
      8'h11: begin kind = CK_DIR;  arg = DIR_REV;  end
      8'h20: begin kind = CK_DIR;  arg = DIR_STOP; end
      8'h30: kind = CK_RST;
      8'h41: begin kind = CK_FREQ; arg = 2'd0; end
      8'h42: begin kind = CK_FREQ; arg = 2'd1; end
      8'h44: begin kind = CK_FREQ; arg = 2'd2; end
      8'h48: begin kind = CK_FREQ; arg = 2'd3; end
      8'h50, 8'h54, 8'h58, 8'h5C: begin kind = CK_POL; arg = code[3:2]; end
      8'h60, 8'h61: begin kind = CK_BASE; arg = {1'b0, code[0]}; end
      default: kind = CK_BAD;
    endcase
  end
endmodule

// File: rtl/hpr_cause_reg.sv
module hpr_cause_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = 8'hFA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rd_clr,
  output logic [W-1:0] value
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (rd_clr ? '0 : q) | (load ? (load_val & MASK) : '0);
  end

  assign value = q;
endmodule

// File: rtl/host_param_regs.sv
module host_param_regs
  import hpr_pkg::*;
#(
  parameter logic [31:0] VERSION  = 32'h48505231,
  parameter int          THR_W    = 10,
  parameter logic [1:0]  DEF_FREQ = 2'd2,
  parameter logic [15:0] WIN_LO   = 16'h0060,
  parameter logic [15:0] WIN_HI   = 16'hEE03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack,
  output logic              host_err,
  input  logic [7:0]        status_in,
  input  logic [7:0]        switch_in,
  input  logic [15:0]       meas_freq,
  input  logic              cause_load,
  input  logic [7:0]        cause_in,
  output logic              pwm_hiz,
  output logic [1:0]        pwm_freq,
  output logic [1:0]        pwm_pol,
  output logic [7:0]        dead_time,
  output logic              base_50hz,
  output logic [1:0]        dir_cmd,
  output logic              reset_req,
  output logic [15:0]       accel_rate,
  output logic [15:0]       speed_cmd,
  output logic [7:0]        boost_lvl,
  output logic [15:0]       fault_tmo,
  output logic [THR_W-1:0]  vbus_brake,
  output logic [THR_W-1:0]  vbus_brownout,
  output logic [THR_W-1:0]  vbus_over
);
  localparam logic [7:0] CAUSE_MASK = 8'hFA;
  localparam logic [2:0] SETUP_ONES = 3'b111;

  reg_desc_t desc;
  logic      rd_window;
  cmd_kind_e cmd_kind;
  logic [1:0] cmd_arg;
  logic [7:0] cause_val;

  hpr_addr_dec #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .THR_W(THR_W)) u_dec (
    .addr(host_addr), .desc(desc), .rd_window(rd_window)
  );

  hpr_cmd_dec u_cmd (
    .code(host_wdata[7:0]), .kind(cmd_kind), .arg(cmd_arg)
  );

  // State
  logic [7:0]       dt_q, boost_q, snap_q;
  logic [1:0]       pol_q, freq_q, dir_q;
  logic             base_q;
  logic [15:0]      accel_q, speed_q, ftmo_q;
  logic [THR_W-1:0] vbrk_q, vbrn_q, vovr_q;
  logic             dt_set, pol_set, base_set, accel_set, speed_set;
  logic [7:0]       setup_val;

  assign setup_val = {SETUP_ONES, base_set, speed_set, accel_set, pol_set, dt_set};
  assign pwm_hiz   = ~(dt_set & pol_set);

  // Access qualification
  logic       rd_go, wr_go, both_go;
  logic [2:0] sz_bytes;
  logic       size_ok;

  assign rd_go   = host_rd & ~host_wr;
  assign wr_go   = host_wr & ~host_rd;
  assign both_go = host_rd & host_wr;

  always_comb begin
    case (host_size)
      2'd0:    sz_bytes = 3'd1;
      2'd1:    sz_bytes = 3'd2;
      2'd2:    sz_bytes = 3'd4;
      default: sz_bytes = 3'd0;
    endcase
  end
  assign size_ok = (sz_bytes == desc.nbytes) && (sz_bytes != 3'd0);

  // Read path
  logic [DATA_W-1:0] rd_val;
  logic              rd_err, snap_ld, cause_rd;

  always_comb begin
    rd_val   = '0;
    rd_err   = 1'b0;
    snap_ld  = 1'b0;
    cause_rd = 1'b0;
    if (!rd_window || sz_bytes == 3'd0) begin
      rd_err = 1'b1;
    end else if (!desc.rd_ok) begin
      rd_val = '0;
    end else if (desc.id == RG_FRQH && sz_bytes == 3'd1) begin
      rd_val  = {24'd0, meas_freq[15:8]};
      snap_ld = 1'b1;
    end else if (!size_ok) begin
      rd_err = 1'b1;
    end else begin
      case (desc.id)
        RG_DEAD:  rd_val = {24'd0, dt_q};
        RG_ACCEL: rd_val = {16'd0, accel_q};
        RG_SPEED: rd_val = {16'd0, speed_q};
        RG_VBRK:  rd_val = 32'(vbrk_q);
        RG_VBRN:  rd_val = 32'(vbrn_q);
        RG_VOVR:  rd_val = 32'(vovr_q);
        RG_FTMO:  rd_val = {16'd0, ftmo_q};
        RG_BOOST: rd_val = {24'd0, boost_q};
        RG_FRQH:  rd_val = {16'd0, meas_freq};
        RG_FRQL:  rd_val = {24'd0, snap_q};
        RG_SETUP: rd_val = {24'd0, setup_val};
        RG_STAT:  rd_val = {24'd0, status_in};
        RG_SWIN:  rd_val = {24'd0, switch_in};
        RG_VER:   rd_val = VERSION;
        RG_CAUSE: begin rd_val = {24'd0, cause_val}; cause_rd = 1'b1; end
        default:  rd_val = '0;
      endcase
    end
  end

  // Write path
  logic wr_err, cmd_bad, wr_do;

  always_comb begin
    cmd_bad = 1'b0;
    case (cmd_kind)
      CK_BAD:  cmd_bad = 1'b1;
      CK_POL:  cmd_bad = pol_set;
      CK_FREQ: cmd_bad = pwm_hiz;
      default: cmd_bad = 1'b0;
    endcase
  end

  assign wr_err = !desc.wr_ok || !size_ok ||
                  (host_wdata > {16'd0, desc.vmax}) ||
                  (desc.id == RG_DEAD && dt_set) ||
                  (desc.id == RG_CMD && cmd_bad);
  assign wr_do  = wr_go && !wr_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_q <= '0; boost_q <= '0; pol_q <= '0; freq_q <= DEF_FREQ;
      dir_q <= DIR_STOP; base_q <= 1'b0;
      accel_q <= '0; speed_q <= '0; ftmo_q <= '0;
      vbrk_q <= '0; vbrn_q <= '0; vovr_q <= '0;
      dt_set <= 1'b0; pol_set <= 1'b0; base_set <= 1'b0;
      accel_set <= 1'b0; speed_set <= 1'b0;
    end else if (wr_do) begin
      case (desc.id)
        RG_DEAD:  begin dt_q <= host_wdata[7:0]; dt_set <= 1'b1; end
        RG_ACCEL: begin accel_q <= host_wdata[15:0]; accel_set <= 1'b1; end
        RG_SPEED: begin speed_q <= host_wdata[15:0]; speed_set <= 1'b1; end
        RG_VBRK:  vbrk_q  <= host_wdata[THR_W-1:0];
        RG_VBRN:  vbrn_q  <= host_wdata[THR_W-1:0];
        RG_VOVR:  vovr_q  <= host_wdata[THR_W-1:0];
        RG_FTMO:  ftmo_q  <= host_wdata[15:0];
        RG_BOOST: boost_q <= host_wdata[7:0];
        RG_CMD: begin
          case (cmd_kind)
            CK_DIR:  dir_q  <= cmd_arg;
            CK_FREQ: freq_q <= cmd_arg;
            CK_POL:  begin pol_q <= cmd_arg; pol_set <= 1'b1; end
            CK_BASE: begin base_q <= cmd_arg[0]; base_set <= 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // Byte snapshot for torn-free byte reads of the live frequency
  always_ff @(posedge clk) begin
    if (rst)                            snap_q <= '0;
    else if (rd_go && !rd_err && snap_ld) snap_q <= meas_freq[7:0];
  end

  hpr_cause_reg #(.W(8), .MASK(CAUSE_MASK)) u_cause (
    .clk(clk), .rst(rst), .load(cause_load), .load_val(cause_in),
    .rd_clr(rd_go && !rd_err && cause_rd), .value(cause_val)
  );

  // Registered response
  logic              ack_q, err_q, rreq_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0; rreq_q <= 1'b0;
    end else begin
      ack_q   <= host_rd | host_wr;
      err_q   <= both_go | (rd_go & rd_err) | (wr_go & wr_err);
      rdata_q <= (rd_go && !rd_err) ? rd_val : '0;
      rreq_q  <= wr_do && (desc.id == RG_CMD) && (cmd_kind == CK_RST);
    end
  end

  assign host_ack      = ack_q;
  assign host_err      = err_q;
  assign host_rdata    = rdata_q;
  assign reset_req     = rreq_q;
  assign pwm_freq      = freq_q;
  assign pwm_pol       = pol_q;
  assign dead_time     = dt_q;
  assign base_50hz     = base_q;
  assign dir_cmd       = dir_q;
  assign accel_rate    = accel_q;
  assign speed_cmd     = speed_q;
  assign boost_lvl     = boost_q;
  assign fault_tmo     = ftmo_q;
  assign vbus_brake    = vbrk_q;
  assign vbus_brownout = vbrn_q;
  assign vbus_over     = vovr_q;
endmodule

// File: rtl/hpr_chk.sv
module hpr_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_rd,
  input logic        host_wr,
  input logic        host_ack,
  input logic        host_err,
  input logic [31:0] host_rdata,
  input logic        pwm_hiz,
  input logic [1:0]  pwm_freq,
  input logic [1:0]  pwm_pol,
  input logic [7:0]  dead_time,
  input logic        reset_req
);
  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) |=> host_ack);
  assert_no_spurious_ack_R1: assert property (@(posedge clk) disable iff (rst)
    !(host_rd || host_wr) |=> !host_ack);
  assert_err_with_ack_R1: assert property (@(posedge clk) disable iff (rst)
    host_err |-> (host_ack && host_rdata == 32'd0));
  assert_hiz_release_sticks_R5: assert property (@(posedge clk) disable iff (rst)
    !pwm_hiz |=> !pwm_hiz);
  assert_freq_locked_in_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    pwm_hiz |=> $stable(pwm_freq));
  assert_once_values_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pwm_hiz |=> ($stable(dead_time) && $stable(pwm_pol)));
  assert_reset_req_from_write_R3: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(host_wr) && host_ack && !host_err));
  assert_reset_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
endmodule

bind host_param_regs hpr_chk u_chk (.*);

// File: tb/sim_host_param_regs.sv
module sim_host_param_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h48505231;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_rdata;
  logic        host_ack, host_err;
  logic [7:0]  status_in = 8'h5A, switch_in = 8'h60;
  logic [15:0] meas_freq = '0;
  logic        cause_load = 1'b0;
  logic [7:0]  cause_in = '0;
  logic        pwm_hiz, base_50hz, reset_req;
  logic [1:0]  pwm_freq, pwm_pol, dir_cmd;
  logic [7:0]  dead_time, boost_lvl;
  logic [15:0] accel_rate, speed_cmd, fault_tmo;
  logic [9:0]  vbus_brake, vbus_brownout, vbus_over;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_param_regs #(.VERSION(VER)) u0 (
    .clk, .rst, .host_addr, .host_size, .host_wdata, .host_rd, .host_wr,
    .host_rdata, .host_ack, .host_err, .status_in, .switch_in, .meas_freq,
    .cause_load, .cause_in, .pwm_hiz, .pwm_freq, .pwm_pol, .dead_time,
    .base_50hz, .dir_cmd, .reset_req, .accel_rate, .speed_cmd, .boost_lvl,
    .fault_tmo, .vbus_brake, .vbus_brownout, .vbus_over
  );

  int tests = 0, fails = 0;
  logic        exp_err_q[$];
  logic [31:0] exp_dat_q[$];
  string       exp_tag_q[$];

  // Monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (!rst && host_ack) begin
      tests++;
      if (exp_err_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected response err=%0b data=%h", host_err, host_rdata);
      end else begin
        automatic logic        ee  = exp_err_q.pop_front();
        automatic logic [31:0] ed  = exp_dat_q.pop_front();
        automatic string       tag = exp_tag_q.pop_front();
        if (host_err !== ee || host_rdata !== ed) begin
          fails++;
          $display("FAIL %s: act err=%0b data=%h exp err=%0b data=%h",
                   tag, host_err, host_rdata, ee, ed);
        end
      end
    end
  end

  task automatic access(input bit rd, input bit wr, input logic [15:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input bit ee, input logic [31:0] ed, input string tag);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
    exp_err_q.push_back(ee); exp_dat_q.push_back(ed); exp_tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input bit ee,
                    input logic [31:0] ed, input string tag);
    access(1'b1, 1'b0, a, sz, 32'd0, ee, ee ? 32'd0 : ed, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd,
                    input bit ee, input string tag);
    access(1'b0, 1'b1, a, sz, wd, ee, 32'd0, tag);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state
    chk("R5 hiz after reset", 32'(pwm_hiz), 1);
    chk("R5 default freq", 32'(pwm_freq), 2);
    chk("R3 dir after reset", 32'(dir_cmd), 0);
    rd(16'h00AE, 2'd0, 0, 32'hE0, "R6 setup reset");
    // Read window
    rd(16'h0050, 2'd0, 1, 0, "R2 below window");
    rd(16'hEE04, 2'd0, 1, 0, "R2 above window");
    rd(16'h0001, 2'd0, 0, 32'h60, "R2 R9 switch exception");
    rd(16'h0100, 2'd0, 0, 0, "R2 unmapped in window");
    rd(16'h1000, 2'd0, 0, 0, "R2 write-only in window");
    // Frequency refused while high impedance
    wr(16'h1000, 2'd0, 32'h42, 1, "R5 freq while hiz");
    chk("R5 freq unchanged", 32'(pwm_freq), 2);
    // Dead time and polarity
    wr(16'h0036, 2'd0, 32'h28, 0, "R4 dead first");
    chk("R4 dead value", 32'(dead_time), 32'h28);
    chk("R5 hiz with dead only", 32'(pwm_hiz), 1);
    rd(16'h00AE, 2'd0, 0, 32'hE1, "R6 setup dead");
    wr(16'h1000, 2'd0, 32'h54, 0, "R4 pol first");
    chk("R4 pol value", 32'(pwm_pol), 1);
    chk("R5 hiz released", 32'(pwm_hiz), 0);
    rd(16'h00AE, 2'd0, 0, 32'hE3, "R6 setup pol");
    wr(16'h0036, 2'd0, 32'h10, 1, "R4 dead second");
    chk("R4 dead kept", 32'(dead_time), 32'h28);
    wr(16'h1000, 2'd0, 32'h58, 1, "R4 pol second");
    chk("R4 pol kept", 32'(pwm_pol), 1);
    rd(16'h0036, 2'd0, 0, 32'h28, "R2 R4 dead readback");
    wr(16'h1000, 2'd0, 32'h48, 0, "R5 freq write");
    chk("R5 freq value", 32'(pwm_freq), 3);
    // Command decode
    wr(16'h1000, 2'd0, 32'h11, 0, "R3 reverse");
    chk("R3 dir reverse", 32'(dir_cmd), 2);
    wr(16'h1000, 2'd0, 32'h10, 0, "R3 forward");
    chk("R3 dir forward", 32'(dir_cmd), 1);
    wr(16'h1000, 2'd0, 32'h33, 1, "R3 bad code");
    chk("R3 dir unchanged", 32'(dir_cmd), 1);
    wr(16'h1000, 2'd0, 32'h20, 0, "R3 stop");
    chk("R3 dir stop", 32'(dir_cmd), 0);
    wr(16'h1000, 2'd0, 32'h61, 0, "R3 base 50");
    chk("R3 base 50", 32'(base_50hz), 1);
    rd(16'h00AE, 2'd0, 0, 32'hF3, "R6 setup base");
    wr(16'h1000, 2'd0, 32'h30, 0, "R3 reset cmd");
    chk("R3 reset pulse high", 32'(reset_req), 1);
    @(negedge clk);
    chk("R3 reset pulse low", 32'(reset_req), 0);
    // Range and size checks
    wr(16'h0060, 2'd1, 32'h8000, 1, "R8 accel over");
    wr(16'h0060, 2'd0, 32'h12, 1, "R8 accel size");
    chk("R8 accel unchanged", 32'(accel_rate), 0);
    wr(16'h0060, 2'd1, 32'h1234, 0, "R8 accel ok");
    chk("R8 accel value", 32'(accel_rate), 32'h1234);
    rd(16'h0060, 2'd1, 0, 32'h1234, "R8 accel read");
    wr(16'h0062, 2'd1, 32'h7FFF, 0, "R8 speed max");
    rd(16'h00AE, 2'd0, 0, 32'hFF, "R6 setup full");
    wr(16'h0064, 2'd1, 32'h400, 1, "R8 brake over");
    wr(16'h0064, 2'd1, 32'h3FF, 0, "R8 brake max");
    chk("R8 brake value", 32'(vbus_brake), 32'h3FF);
    wr(16'h006C, 2'd0, 32'h100, 1, "R8 boost over");
    chk("R8 boost unchanged", 32'(boost_lvl), 0);
    wr(16'h006A, 2'd1, 32'hFFFF, 0, "R8 timeout max");
    rd(16'h006A, 2'd1, 0, 32'hFFFF, "R8 timeout read");
    // Read-only and unmapped writes
    wr(16'h00C8, 2'd0, 32'h01, 1, "R9 status write");
    wr(16'h00AE, 2'd0, 32'hE0, 1, "R9 setup write");
    wr(16'h2000, 2'd0, 32'h01, 1, "R9 unmapped write");
    rd(16'h00C8, 2'd0, 0, 32'h5A, "R9 status read");
    // Version and snapshot
    rd(16'hEE00, 2'd2, 0, VER, "R10 version");
    meas_freq = 16'h1A2B;
    rd(16'h0085, 2'd0, 0, 32'h1A, "R10 freq high byte");
    meas_freq = 16'h3C4D;
    rd(16'h0086, 2'd0, 0, 32'h2B, "R10 freq snapshot");
    rd(16'h0085, 2'd1, 0, 32'h3C4D, "R10 freq word");
    // Cause register
    @(negedge clk);
    cause_load = 1'b1; cause_in = 8'hFF;
    @(negedge clk);
    cause_load = 1'b0;
    rd(16'hFE01, 2'd0, 0, 32'hFA, "R7 cause first");
    rd(16'hFE01, 2'd0, 0, 32'h00, "R7 cause second");
    // Protocol errors
    access(1'b1, 1'b1, 16'h0060, 2'd1, 32'd0, 1, 0, "R1 both strobes");
    rd(16'h0060, 2'd3, 1, 0, "R1 bad size");
    @(negedge clk);
    chk("R1 idle no ack", 32'(host_ack), 0);
    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", 32'(exp_err_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule